// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Sequencer

This block sits between a set of free-running clock sources and the output pads. It gates every output with its own enable bit, and it runs an orderly power-down in which each output finishes its current high pulse and then stays low. It also reads a single active-low shared pin, whose meaning changes over time. For a fixed window after reset the pin is a board-test select. Low with the function-select input at 0 floats every output. Low with the function-select input at 1 flags test-clock mode. After the window the pin becomes a power-down request, as long as it is not held low at that moment and a register bit allows it.

All logic runs on one system clock. The source clocks and the CPU reference clock arrive as levels that are sampled on that clock. A power-down request counts only after the pin has been seen low on two consecutive CPU rising edges. Each lane takes the stop request through its own two-flop synchroniser. Once every lane has stopped, the oscillator and VCO enables drop. When the pin is released, the enables return at once, and the outputs resume after a stabilisation count.

Top module: `clkout_pd_ctrl`

## Requirements
- R1: Power-down starts only after the shared pin is seen low on two consecutive CPU rising edges while the pin is in its power-down role. A single low edge followed by a high edge starts nothing, and `pd_active` stays 0.
- R2: Once power-down starts, each output keeps toggling until its source is next low and then stays low. A high output whose source is still high is never cut short. The stop request reaches each lane through two register stages.
- R3: While `pd_active` is 1, every `clk_out` bit is 0 and `osc_en` is 0. The block enters this state in the cycle after the last lane has stopped.
- R4: An output whose `out_en` bit is 0 is 0 one cycle later and does not toggle.
- R5: After reset, `clk_out` is all zero, `out_oe` is 1 with the pin high, `osc_en` and `vco_en` are 1, and `pd_active` is 0.
- R6: In the pin's tristate role, with the pin low and `fsel` 0, `out_oe` is 0. Otherwise `out_oe` is 1.
- R7: In the pin's tristate role, with the pin low and `fsel` 1, `test_mode` is 1. Otherwise `test_mode` is 0.
- R8: The pin stays in its tristate role for the first `PWRUP_CYCLES` cycles after reset. After that it changes to its power-down role in the first cycle in which it is high. While it is held low it keeps the tristate role.
- R9: While `pin_role_pd` is 0, the pin acts in its tristate role (1 selects the power-down role).
- R10: In power-down, a high pin, or loss of the power-down role, brings `osc_en` and `vco_en` back the next cycle. The stop request is withdrawn `STAB_CYCLES` cycles later, and the outputs then resume on a low source phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_clk | input | N_OUT | Sampled levels of the source clocks |
| out_en | input | N_OUT | Per-output enable, 1 = running |
| cpu_clk_lvl | input | 1 | Sampled level of the CPU reference clock |
| share_pin_n | input | 1 | Shared active-low test / power-down pin |
| fsel | input | 1 | Function-select level used in the tristate role |
| pin_role_pd | input | 1 | Register bit: 1 = power-down role, 0 = tristate role |
| clk_out | output | N_OUT | Gated clock outputs |
| out_oe | output | 1 | Output driver enable, 0 = high impedance |
| test_mode | output | 1 | Test-clock mode select |
| osc_en | output | 1 | Oscillator enable |
| vco_en | output | 1 | VCO enable |
| pd_active | output | 1 | Fully powered down |

## Verification
The bench builds the block with four lanes, a 20-cycle power-up window and a 6-cycle stabilisation count. The short window lets one run hold the pin low across the moment the window ends. The same run later sees the pin move to its power-down role. Each lane's source toggles at a different rate, so the lanes stop in different cycles, and the two-edge qualification falls on a CPU clock that is slower than the system clock. The short stabilisation count brings a complete stop, idle and resume cycle, followed by the return to the tristate role, within a few hundred cycles.

// File: rtl/clk_ctl_pkg.sv
// Shared types for the clock output gating block.
// Assumes: nothing beyond IEEE 1800-2017.
package clk_ctl_pkg;
    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_STOP = 2'd1,
        PS_OFF  = 2'd2,
        PS_WAKE = 2'd3
    } pd_state_t;
endpackage

// File: rtl/ccg_pin_mode.sv
// Decides which role the shared pin plays.
// Holds the tristate role for PWRUP_CYCLES cycles after reset, then moves to
// the power-down role on the first cycle the pin is high. The register bit
// can force the tristate role at any time.
// Assumes: pin_n is already synchronous to clk.
module ccg_pin_mode #(
    parameter int PWRUP_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic role_pd_bit,
    output logic pd_role
);
    localparam int CW = $clog2(PWRUP_CYCLES + 1);

    logic [CW-1:0] win_cnt;
    logic          win_done;
    logic          pd_fn;

    // Power-up window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            win_done <= 1'b0;
        end else if (!win_done) begin
            win_cnt  <= win_cnt + 1'b1;
            win_done <= (win_cnt == CW'(PWRUP_CYCLES - 1));
        end
    end

    // Latch the pin's function change once the window has closed and the pin is high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pd_fn <= 1'b0;
        else if (win_done && !pd_fn && pin_n)
            pd_fn <= 1'b1;
    end

    assign pd_role = pd_fn && role_pd_bit;

    a_r8_no_switch_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |-> !pd_fn);
    a_r8_no_switch_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_fn && !pin_n) |=> !pd_fn);
endmodule

// File: rtl/ccg_pd_seq.sv
// Power-down sequencer.
// Qualifies the request on two consecutive CPU rising edges with the pin low,
// waits until every lane reports stopped, drops the oscillator and VCO
// enables, and on release counts STAB_CYCLES before letting the lanes run again.
// Assumes: cpu_lvl is a sampled level, so the edge is found against the previous sample.
module ccg_pd_seq
    import clk_ctl_pkg::*;
#(
    parameter int STAB_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_role,
    input  logic pin_n,
    input  logic cpu_lvl,
    input  logic all_stopped,
    output logic stop_req,
    output logic osc_en,
    output logic vco_en,
    output logic pd_active
);
    localparam int SW = $clog2(STAB_CYCLES + 1);

    pd_state_t     state;
    logic          cpu_q;
    logic          cpu_rise;
    logic [1:0]    low_cnt;
    logic [SW-1:0] stab_cnt;

    assign cpu_rise = cpu_lvl && !cpu_q;

    // Previous CPU level, used to find rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_q <= 1'b0;
        else        cpu_q <= cpu_lvl;
    end

    // Count consecutive CPU rising edges that see the pin low, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n || !pd_role || state != PS_RUN)
            low_cnt <= 2'd0;
        else if (cpu_rise)
            low_cnt <= pin_n ? 2'd0 : ((low_cnt == 2'd2) ? 2'd2 : low_cnt + 2'd1);
    end

    // Main power-down state sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PS_RUN;
            stab_cnt <= '0;
        end else begin
            case (state)
                PS_RUN:  if (low_cnt == 2'd2) state <= PS_STOP;
                PS_STOP: if (all_stopped) state <= PS_OFF;
                PS_OFF: begin
                    if (pin_n || !pd_role) begin
                        state    <= PS_WAKE;
                        stab_cnt <= '0;
                    end
                end
                PS_WAKE: begin
                    if (stab_cnt == SW'(STAB_CYCLES - 1)) state <= PS_RUN;
                    else                                  stab_cnt <= stab_cnt + 1'b1;
                end
                default: state <= PS_RUN;
            endcase
        end
    end

    assign stop_req  = (state != PS_RUN);
    assign osc_en    = (state != PS_OFF);
    assign vco_en    = (state != PS_OFF);
    assign pd_active = (state == PS_OFF);

    a_r1_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req) |-> ($past(low_cnt) == 2'd2));
    a_r3_off_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_active) |-> $past(all_stopped));
    a_r10_wake_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && (pin_n || !pd_role)) |=> (osc_en && vco_en));
endmodule

// File: rtl/ccg_lane.sv
// One gated clock lane.
// Brings the stop request in through a two-flop synchroniser, and changes its
// run state only while the source is low, so that no high pulse is cut short.
// A cleared enable bit forces the output low.
// Assumes: src is a sampled clock level; clk_o is registered.
module ccg_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic en,
    input  logic stop_req,
    output logic clk_o,
    output logic stopped
);
    logic sync1, sync2;
    logic run, run_nxt;

    // Two-flop synchroniser for the stop request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= stop_req;
            sync2 <= sync1;
        end
    end

    // Run state may change only on a low source phase.
    always_comb run_nxt = src ? run : !sync2;

    // Register the run state and the gated output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            clk_o <= 1'b0;
        end else begin
            run   <= run_nxt;
            clk_o <= src && run_nxt && en;
        end
    end

    assign stopped = !run;

    a_r4_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !clk_o);
    a_r2_no_truncate: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_o && src && en) |=> clk_o);
endmodule

// File: rtl/clkout_pd_ctrl.sv
// Clock output gating and power-down controller (top).
// Combines the pin-role logic, the power-down sequencer and N_OUT gated
// lanes. The tristate and test-mode outputs decode the pin directly while it
// is in its tristate role.
// Assumes: every input is synchronous to clk.
module clkout_pd_ctrl #(
    parameter int N_OUT        = 4,
    parameter int PWRUP_CYCLES = 1000,
    parameter int STAB_CYCLES  = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] src_clk,
    input  logic [N_OUT-1:0] out_en,
    input  logic             cpu_clk_lvl,
    input  logic             share_pin_n,
    input  logic             fsel,
    input  logic             pin_role_pd,
    output logic [N_OUT-1:0] clk_out,
    output logic             out_oe,
    output logic             test_mode,
    output logic             osc_en,
    output logic             vco_en,
    output logic             pd_active
);
    logic             pd_role;
    logic             stop_req;
    logic [N_OUT-1:0] lane_stopped;
    logic             tri_low;

    ccg_pin_mode #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (share_pin_n),
        .role_pd_bit(pin_role_pd),
        .pd_role    (pd_role)
    );

    ccg_pd_seq #(.STAB_CYCLES(STAB_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_role    (pd_role),
        .pin_n      (share_pin_n),
        .cpu_lvl    (cpu_clk_lvl),
        .all_stopped(&lane_stopped),
        .stop_req   (stop_req),
        .osc_en     (osc_en),
        .vco_en     (vco_en),
        .pd_active  (pd_active)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_lane
        ccg_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_clk[i]),
            .en      (out_en[i]),
            .stop_req(stop_req),
            .clk_o   (clk_out[i]),
            .stopped (lane_stopped[i])
        );
    end

    // Board-test decode while the pin is in its tristate role.
    always_comb begin
        tri_low   = !pd_role && !share_pin_n;
        out_oe    = !(tri_low && !fsel);
        test_mode = tri_low && fsel;
    end

    a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |-> (clk_out == '0 && !osc_en && !vco_en));
    a_r6_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(test_mode && !out_oe));
endmodule

// File: tb/tb_clkout_pd_ctrl.sv
// Bench: a behavioural reference model, stepped on every clock and compared at each falling edge.
module tb_clkout_pd_ctrl;
    localparam int N  = 4;
    localparam int PW = 20;
    localparam int ST = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_clk = '0;
    logic [N-1:0] out_en = '1;
    logic         cpu_clk_lvl = 1'b0;
    logic         share_pin_n = 1'b1;
    logic         fsel = 1'b0;
    logic         pin_role_pd = 1'b1;
    logic [N-1:0] clk_out;
    logic         out_oe, test_mode, osc_en, vco_en, pd_active;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string tag = "R5";
    bit    started = 0;

    clkout_pd_ctrl #(.N_OUT(N), .PWRUP_CYCLES(PW), .STAB_CYCLES(ST)) dut (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .out_en(out_en),
        .cpu_clk_lvl(cpu_clk_lvl), .share_pin_n(share_pin_n), .fsel(fsel),
        .pin_role_pd(pin_role_pd), .clk_out(clk_out), .out_oe(out_oe),
        .test_mode(test_mode), .osc_en(osc_en), .vco_en(vco_en), .pd_active(pd_active)
    );

    always #4 clk = ~clk;

    // Reference model state.
    int     m_win;
    bit     m_windone, m_pdfn, m_cpuq;
    int     m_low;
    int     m_phase;          // 0 running, 1 stopping, 2 off, 3 waking
    int     m_stab;
    bit     m_s1, m_s2;
    bit     m_run [N];
    bit     m_out [N];

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_win = 0; m_windone = 0; m_pdfn = 0; m_cpuq = 0; m_low = 0;
            m_phase = 0; m_stab = 0; m_s1 = 0; m_s2 = 0;
            for (int i = 0; i < N; i++) begin m_run[i] = 0; m_out[i] = 0; end
        end else begin
            bit role, rise, allstop, req;
            int nphase, nlow;
            role = m_pdfn && pin_role_pd;
            rise = cpu_clk_lvl && !m_cpuq;
            allstop = 1;
            for (int i = 0; i < N; i++) if (m_run[i]) allstop = 0;
            req = (m_phase != 0);
            nphase = m_phase;
            if (m_phase == 0 && m_low == 2) nphase = 1;
            else if (m_phase == 1 && allstop) nphase = 2;
            else if (m_phase == 2 && (share_pin_n || !role)) begin nphase = 3; m_stab = 0; end
            else if (m_phase == 3) begin
                if (m_stab == ST - 1) nphase = 0; else m_stab++;
            end
            nlow = m_low;
            if (!role || m_phase != 0) nlow = 0;
            else if (rise) nlow = share_pin_n ? 0 : ((m_low >= 2) ? 2 : m_low + 1);
            for (int i = 0; i < N; i++) begin
                if (!src_clk[i]) m_run[i] = !m_s2;
                m_out[i] = src_clk[i] && m_run[i] && out_en[i];
            end
            m_s2 = m_s1; m_s1 = req;
            if (m_windone && !m_pdfn && share_pin_n) m_pdfn = 1;
            if (!m_windone) begin m_windone = (m_win == PW - 1); m_win++; end
            m_cpuq = cpu_clk_lvl;
            m_phase = nphase; m_low = nlow;
        end
    end

    task automatic chk(string sig, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s cyc=%0d actual=%0h expected=%0h", tag, sig, cyc, got, exp);
        end
    endtask

    // Compare every output on each falling edge, before the inputs move.
    always @(negedge clk) begin
        if (started) begin
            bit role, tl;
            logic [N-1:0] eo;
            role = m_pdfn && pin_role_pd;
            tl = !role && !share_pin_n;
            for (int i = 0; i < N; i++) eo[i] = m_out[i];
            chk("clk_out(R2,R4)", int'(clk_out), int'(eo));
            chk("out_oe(R6)", int'(out_oe), int'(!(tl && !fsel)));
            chk("test_mode(R7)", int'(test_mode), int'(tl && fsel));
            chk("osc_en(R3)", int'(osc_en), int'(m_phase != 2));
            chk("vco_en(R10)", int'(vco_en), int'(m_phase != 2));
            chk("pd_active(R1)", int'(pd_active), int'(m_phase == 2));
        end
    end

    // Free-running source and CPU levels, each lane at its own rate.
    always @(negedge clk) begin
        #1;
        cyc++;
        for (int i = 0; i < N; i++) src_clk[i] = ((cyc / (i + 1)) % 2) != 0;
        cpu_clk_lvl = ((cyc / 2) % 2) != 0;
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    // Watchdog.
    initial begin
        #1600000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tag = "R5"; step(3); rst_n = 1; step(3);
        tag = "R7"; share_pin_n = 0; fsel = 1; step(4);
        tag = "R6"; fsel = 0; step(4);
        tag = "R8"; step(PW + 5);              // still low as the window closes
        share_pin_n = 1; step(4);
        share_pin_n = 0; fsel = 0; step(1);   // power-down role now: oe stays 1
        share_pin_n = 1; step(10);
        tag = "R1"; share_pin_n = 0; step(3); share_pin_n = 1; step(12);
        tag = "R4"; out_en = 4'b1011; step(16); out_en = '1; step(4);
        tag = "R2"; share_pin_n = 0; step(30);
        tag = "R3"; step(10);
        tag = "R10"; share_pin_n = 1; step(ST + 20);
        tag = "R9"; pin_role_pd = 0; share_pin_n = 0; fsel = 0; step(5);
        fsel = 1; step(5);
        share_pin_n = 1; pin_role_pd = 1; step(8);
        tag = "R2"; share_pin_n = 0; step(20);
        tag = "R9"; pin_role_pd = 0; step(ST + 20);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule